// File: doc/BRIEF.md
# Lane-Banked Matrix Register File

This block holds the architected matrix registers of a two-dimensional SIMD unit. Each register is a stack of rows of 64-bit packed sub-word data. The rows are spread across parallel lanes, and each lane keeps its rows in its own private bank. A lane can read and write only its own bank, so no crossbar links every storage location to every arithmetic unit.

Functional units open read or write streams. Each stream names a register and a vector length. The stream then walks through the register one beat per cycle, and every beat moves one row per lane. Each bank has a small, fixed number of read and write ports. When more streams want a bank in one cycle than it has ports for, a fixed-priority arbiter holds back the excess streams for a cycle. Streams of functional unit 0 go first, and within a unit the lower slot goes first.

Streams are flattened by index. Read stream `s` is slot `s % RD_PER_FU` of unit `s / RD_PER_FU`, and write streams follow the same rule. Lane `l` of stream `s` sits at bits `[(s*NLANE+l)*64 +: 64]` of the data buses and at bit `s*NLANE+l` of the lane-mask bus. Register numbers are 4 bits at `[s*4 +: 4]`. Vector lengths are 5 bits at `[s*5 +: 5]`.

Top module: `matrix_lane_rf`

## Requirements
- R1: After reset, no stream is busy, no read data is valid, no write is acknowledged, and all read data lanes are zero.
- R2: Row r of a register lives in lane r mod 4 at beat r div 4. A read returns beat b with row 4b+l on lane l, so a full read yields rows 0..15 in order.
- R3: An uncontested access of vector length VL takes ceil(VL/4) beats on consecutive cycles. For a read started at clock edge k, data is valid after edges k+1 through k+ceil(VL/4), and the stream is idle again after that. For a write started at edge k, wr_ack is high from edge k until the last beat commits.
- R4: A write with vector length VL changes only rows 0..VL-1. In the last beat, lanes whose row is VL or above write nothing, and rows at or above VL keep their old contents.
- R5: With each valid read beat the block presents a lane mask. Bit l is 1 exactly when row 4b+l is below VL. Masked-off lanes carry zero data.
- R6: At most 3 read streams use any bank in one cycle. A stream is granted only if every lane it needs still has a free port, and streams are considered in index order. Four concurrent full-width reads therefore serve streams 0-2 in one cycle and stream 3 in the next.
- R7: At most 2 write streams use any bank in one cycle, with the same index-order priority. Four concurrent full-width writes are acknowledged as 0011 and then 1100.
- R8: When a read and a write hit the same row in the same cycle, the read returns the old contents. There is no bypass.
- R9: A start on a busy stream is ignored, and a start with vector length 0 is ignored.
- R10: A vector length above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 4 | Per read stream: open a read |
| rd_reg | input | 16 | Per read stream: register number, 4 bits each |
| rd_vl | input | 20 | Per read stream: vector length, 5 bits each |
| rd_busy | output | 4 | Per read stream: sequence in progress |
| rd_valid | output | 4 | Per read stream: a beat of data is present |
| rd_lmask | output | 16 | Per read stream and lane: row is live |
| rd_data | output | 1024 | Per read stream and lane: 64-bit row |
| wr_start | input | 4 | Per write stream: open a write |
| wr_reg | input | 16 | Per write stream: register number |
| wr_vl | input | 20 | Per write stream: vector length |
| wr_data | input | 1024 | Per write stream and lane: row for the current beat |
| wr_busy | output | 4 | Per write stream: sequence in progress |
| wr_ack | output | 4 | Per write stream: the current beat commits at the next edge |

## Verification
The bench runs single streams with vector lengths 16, 8, 6 and 20. Full registers confirm the row-to-lane layout. A partial length shows whether the last-beat mask protects the upper rows. The oversize length shows whether it is clamped rather than wrapped. Four simultaneous reads and four simultaneous writes tell correct per-bank port limits and priority apart from over-granting or a wrong stall order. A read and a write to the same row in the same cycle separates no-bypass behaviour from forwarding. Starts issued on a busy stream and with zero length show whether the sequencer protects an open stream.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  // Clamp a requested vector length to the register depth.
  function automatic int clamp_vl(input int vl, input int max_rows);
    return (vl > max_rows) ? max_rows : vl;
  endfunction

  // Row held by lane `lane` during beat `beat`.
  function automatic int row_of(input int beat, input int lane, input int nlane);
    return beat * nlane + lane;
  endfunction

  // A lane is live in a beat when its row is below the vector length.
  function automatic logic lane_live(input int beat, input int lane, input int nlane, input int vl);
    return row_of(beat, lane, nlane) < vl;
  endfunction

  // The beat is the final one when the next beat would start at or past vl.
  function automatic logic final_beat(input int beat, input int nlane, input int vl);
    return row_of(beat + 1, 0, nlane) >= vl;
  endfunction

endpackage

// File: rtl/mrf_seq.sv
module mrf_seq #(
  parameter int NLANE  = 4,
  parameter int NROW   = 16,
  parameter int REG_W  = 4,
  parameter int VL_W   = 5,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [VL_W-1:0]   start_vl,
  input  logic              gnt,
  output logic              busy,
  output logic [REG_W-1:0]  reg_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [NLANE-1:0]  lmask
);

  logic              busy_q;
  logic [REG_W-1:0]  reg_q;
  logic [VL_W-1:0]   vl_q;
  logic [BEAT_W-1:0] beat_q;
  logic              accept;
  logic              last;
  logic [VL_W-1:0]   vl_eff;

  assign accept = start && !busy_q && (start_vl != '0);
  assign vl_eff = VL_W'(mrf_pkg::clamp_vl(int'(start_vl), NROW));
  assign last   = mrf_pkg::final_beat(int'(beat_q), NLANE, int'(vl_q));

  always_comb begin
    for (int l = 0; l < NLANE; l++)
      lmask[l] = busy_q && mrf_pkg::lane_live(int'(beat_q), l, NLANE, int'(vl_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      reg_q  <= '0;
      vl_q   <= '0;
      beat_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      reg_q  <= start_reg;
      vl_q   <= vl_eff;
      beat_q <= '0;
    end else if (busy_q && gnt) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign busy   = busy_q;
  assign reg_o  = reg_q;
  assign beat_o = beat_q;

  // R5: a live beat always has a contiguous mask starting at lane 0
  a_r5_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot({1'b0, lmask} + (NLANE+1)'(1)));

  // R3: a granted non-final beat moves to the next beat
  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && gnt && !last) |=> (busy_q && (beat_q == $past(beat_q) + BEAT_W'(1))));

  // R3: a granted final beat closes the stream
  a_r3_close: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && gnt && last) |=> !busy_q);

  // R9: a stalled stream keeps its register and beat whatever start does
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !gnt) |=> (busy_q && $stable(reg_q) && $stable(beat_q)));

endmodule

// File: rtl/mrf_arb.sv
module mrf_arb #(
  parameter int NSTREAM = 4,
  parameter int NLANE   = 4,
  parameter int NPORT   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTREAM-1:0]         req,
  input  logic [NSTREAM*NLANE-1:0]   lmask,
  output logic [NSTREAM-1:0]         gnt
);

  int   taken [NLANE];
  logic fits;

  // Fixed priority by stream index; a beat is granted on all its lanes or not at all.
  always_comb begin
    gnt  = '0;
    fits = 1'b0;
    for (int l = 0; l < NLANE; l++) taken[l] = 0;
    for (int s = 0; s < NSTREAM; s++) begin
      fits = req[s];
      for (int l = 0; l < NLANE; l++)
        if (lmask[s*NLANE+l] && taken[l] >= NPORT) fits = 1'b0;
      if (fits) begin
        gnt[s] = 1'b1;
        for (int l = 0; l < NLANE; l++)
          if (lmask[s*NLANE+l]) taken[l] = taken[l] + 1;
      end
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [NSTREAM-1:0] col;
    for (genvar s = 0; s < NSTREAM; s++) begin : g_s
      assign col[s] = gnt[s] & lmask[s*NLANE+l];
    end
    // R6 on read instances, R7 on write instances: bank port budget
    a_r6_port_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= NPORT);
  end

  // R6/R7: the highest-priority requester is never held back
  a_r6_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);

endmodule

// File: rtl/mrf_bank.sv
module mrf_bank #(
  parameter int ADDR_W = 6,
  parameter int NRD    = 4,
  parameter int NWR    = 4,
  parameter int WORD_W = 64
) (
  input  logic                    clk,
  input  logic [NRD-1:0]          rd_en,
  input  logic [NRD*ADDR_W-1:0]   rd_addr,
  output logic [NRD*WORD_W-1:0]   rd_data,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR*ADDR_W-1:0]   wr_addr,
  input  logic [NWR*WORD_W-1:0]   wr_data
);

  localparam int ENTRIES = 1 << ADDR_W;

  logic [WORD_W-1:0]     mem [ENTRIES];
  logic [NRD*WORD_W-1:0] rd_q;

  // Reads see the contents before this edge's writes (no bypass).
  always_ff @(posedge clk) begin
    for (int w = 0; w < NWR; w++)
      if (wr_en[w]) mem[wr_addr[w*ADDR_W +: ADDR_W]] <= wr_data[w*WORD_W +: WORD_W];
    for (int r = 0; r < NRD; r++)
      if (rd_en[r]) rd_q[r*WORD_W +: WORD_W] <= mem[rd_addr[r*ADDR_W +: ADDR_W]];
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/matrix_lane_rf.sv
module matrix_lane_rf #(
  parameter int NREG      = 16,
  parameter int NROW      = 16,
  parameter int NLANE     = 4,
  parameter int NFU       = 2,
  parameter int RD_PER_FU = 2,
  parameter int WR_PER_FU = 2,
  parameter int RD_PORTS  = 3,
  parameter int WR_PORTS  = 2,
  parameter int WORD_W    = 64,
  localparam int NRS      = NFU * RD_PER_FU,
  localparam int NWS      = NFU * WR_PER_FU,
  localparam int REG_W    = $clog2(NREG),
  localparam int VL_W     = $clog2(NROW + 1),
  localparam int DEPTH    = NROW / NLANE,
  localparam int BEAT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W   = REG_W + BEAT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NRS-1:0]                rd_start,
  input  logic [NRS*REG_W-1:0]          rd_reg,
  input  logic [NRS*VL_W-1:0]           rd_vl,
  output logic [NRS-1:0]                rd_busy,
  output logic [NRS-1:0]                rd_valid,
  output logic [NRS*NLANE-1:0]          rd_lmask,
  output logic [NRS*NLANE*WORD_W-1:0]   rd_data,
  input  logic [NWS-1:0]                wr_start,
  input  logic [NWS*REG_W-1:0]          wr_reg,
  input  logic [NWS*VL_W-1:0]           wr_vl,
  input  logic [NWS*NLANE*WORD_W-1:0]   wr_data,
  output logic [NWS-1:0]                wr_busy,
  output logic [NWS-1:0]                wr_ack
);

  logic [NRS-1:0]          r_gnt;
  logic [NRS*NLANE-1:0]    r_mask;
  logic [NRS*ADDR_W-1:0]   r_addr;
  logic [NWS-1:0]          w_gnt;
  logic [NWS*NLANE-1:0]    w_mask;
  logic [NWS*ADDR_W-1:0]   w_addr;
  logic [NRS*NLANE-1:0]    r_mask_gnt;
  logic [NRS-1:0]          rd_valid_q;
  logic [NRS*NLANE-1:0]    rd_lmask_q;

  // Read stream sequencers
  for (genvar s = 0; s < NRS; s++) begin : g_rseq
    logic [REG_W-1:0]  sreg;
    logic [BEAT_W-1:0] sbeat;
    mrf_seq #(.NLANE(NLANE), .NROW(NROW), .REG_W(REG_W), .VL_W(VL_W), .BEAT_W(BEAT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(rd_start[s]), .start_reg(rd_reg[s*REG_W +: REG_W]), .start_vl(rd_vl[s*VL_W +: VL_W]),
      .gnt(r_gnt[s]), .busy(rd_busy[s]), .reg_o(sreg), .beat_o(sbeat),
      .lmask(r_mask[s*NLANE +: NLANE]));
    assign r_addr[s*ADDR_W +: ADDR_W] = {sreg, sbeat};
    assign r_mask_gnt[s*NLANE +: NLANE] = r_mask[s*NLANE +: NLANE] & {NLANE{r_gnt[s]}};
  end

  // Write stream sequencers
  for (genvar w = 0; w < NWS; w++) begin : g_wseq
    logic [REG_W-1:0]  sreg;
    logic [BEAT_W-1:0] sbeat;
    mrf_seq #(.NLANE(NLANE), .NROW(NROW), .REG_W(REG_W), .VL_W(VL_W), .BEAT_W(BEAT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(wr_start[w]), .start_reg(wr_reg[w*REG_W +: REG_W]), .start_vl(wr_vl[w*VL_W +: VL_W]),
      .gnt(w_gnt[w]), .busy(wr_busy[w]), .reg_o(sreg), .beat_o(sbeat),
      .lmask(w_mask[w*NLANE +: NLANE]));
    assign w_addr[w*ADDR_W +: ADDR_W] = {sreg, sbeat};
  end

  mrf_arb #(.NSTREAM(NRS), .NLANE(NLANE), .NPORT(RD_PORTS)) u_rarb (
    .clk(clk), .rst_n(rst_n), .req(rd_busy), .lmask(r_mask), .gnt(r_gnt));

  mrf_arb #(.NSTREAM(NWS), .NLANE(NLANE), .NPORT(WR_PORTS)) u_warb (
    .clk(clk), .rst_n(rst_n), .req(wr_busy), .lmask(w_mask), .gnt(w_gnt));

  assign wr_ack = w_gnt;

  // One private bank per lane
  for (genvar l = 0; l < NLANE; l++) begin : g_bank
    logic [NRS-1:0]          ren;
    logic [NWS-1:0]          wen;
    logic [NWS*WORD_W-1:0]   wdat;
    logic [NRS*WORD_W-1:0]   rdat;
    for (genvar s = 0; s < NRS; s++) begin : g_r
      assign ren[s] = r_mask_gnt[s*NLANE + l];
      assign rd_data[(s*NLANE+l)*WORD_W +: WORD_W] =
        rd_lmask_q[s*NLANE + l] ? rdat[s*WORD_W +: WORD_W] : '0;
    end
    for (genvar w = 0; w < NWS; w++) begin : g_w
      assign wen[w] = w_gnt[w] & w_mask[w*NLANE + l];
      assign wdat[w*WORD_W +: WORD_W] = wr_data[(w*NLANE+l)*WORD_W +: WORD_W];
    end
    mrf_bank #(.ADDR_W(ADDR_W), .NRD(NRS), .NWR(NWS), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rd_en(ren), .rd_addr(r_addr), .rd_data(rdat),
      .wr_en(wen), .wr_addr(w_addr), .wr_data(wdat));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= '0;
      rd_lmask_q <= '0;
    end else begin
      rd_valid_q <= r_gnt;
      rd_lmask_q <= r_mask_gnt;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_lmask = rd_lmask_q;

  for (genvar s = 0; s < NRS; s++) begin : g_chk
    // R5: a valid beat always carries lane 0; an idle output carries no lanes
    a_r5_valid_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[s] ? rd_lmask[s*NLANE] : (rd_lmask[s*NLANE +: NLANE] == '0));
  end

endmodule

// File: tb/matrix_lane_rf_tb.sv
module matrix_lane_rf_tb;

  localparam int NS = 4, NL = 4, W = 64, NR = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0]      rd_start;
  logic [NS*4-1:0]    rd_reg;
  logic [NS*5-1:0]    rd_vl;
  logic [NS-1:0]      rd_busy, rd_valid;
  logic [NS*NL-1:0]   rd_lmask;
  logic [NS*NL*W-1:0] rd_data;
  logic [NS-1:0]      wr_start;
  logic [NS*4-1:0]    wr_reg;
  logic [NS*5-1:0]    wr_vl;
  logic [NS*NL*W-1:0] wr_data;
  logic [NS-1:0]      wr_busy, wr_ack;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] model [16][16];

  always #2 clk = ~clk;

  matrix_lane_rf u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_start(rd_start), .rd_reg(rd_reg), .rd_vl(rd_vl), .rd_busy(rd_busy),
    .rd_valid(rd_valid), .rd_lmask(rd_lmask), .rd_data(rd_data),
    .wr_start(wr_start), .wr_reg(wr_reg), .wr_vl(wr_vl), .wr_data(wr_data),
    .wr_busy(wr_busy), .wr_ack(wr_ack));

  function automatic logic [63:0] pat(int r, int row, logic [15:0] seed);
    return {seed, 16'(r), 16'(row), ~seed};
  endfunction

  function automatic int eff_vl(int vl);
    return (vl > NR) ? NR : vl;
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_rd(int s, int r, int vl);
    rd_start[s] = 1'b1;
    rd_reg[s*4 +: 4] = 4'(r);
    rd_vl[s*5 +: 5] = 5'(vl);
  endtask

  task automatic set_wr(int s, int r, int vl);
    wr_start[s] = 1'b1;
    wr_reg[s*4 +: 4] = 4'(r);
    wr_vl[s*5 +: 5] = 5'(vl);
  endtask

  task automatic drive_beat(int s, int r, int b, logic [15:0] seed);
    for (int l = 0; l < NL; l++)
      wr_data[(s*NL+l)*W +: W] = pat(r, b*NL+l, seed);
  endtask

  task automatic commit_beat(int r, int vl, int b, logic [15:0] seed);
    for (int l = 0; l < NL; l++)
      if (b*NL+l < eff_vl(vl)) model[r][b*NL+l] = pat(r, b*NL+l, seed);
  endtask

  // Compare one valid read beat of stream s against the model.
  task automatic verify_beat(int s, int r, int vl, int b, string req);
    check64(req, "rd_valid", 64'(rd_valid[s]), 64'd1);
    for (int l = 0; l < NL; l++) begin
      int  row  = b*NL + l;
      bit  live = row < eff_vl(vl);
      check64(req, "lane mask", 64'(rd_lmask[s*NL+l]), 64'(live));
      check64(req, "lane data", rd_data[(s*NL+l)*W +: W], live ? model[r][row] : 64'd0);
    end
  endtask

  // Single uncontested write; checks beat count (R3).
  task automatic write_run(int s, int r, int vl, logic [15:0] seed, string req);
    int nb = (eff_vl(vl) + NL - 1) / NL;
    int b = 0, cyc = 0;
    @(negedge clk); set_wr(s, r, vl);
    @(posedge clk);
    @(negedge clk); wr_start = '0;
    while (b < nb && cyc < 40) begin
      drive_beat(s, r, b, seed);
      if (wr_ack[s]) begin commit_beat(r, vl, b, seed); b++; end
      cyc++;
      @(negedge clk);
    end
    check64(req, "write beat cycles", 64'(cyc), 64'(nb));
    check64(req, "write stream idle", 64'(wr_busy[s]), 64'd0);
  endtask

  // Single uncontested read with per-beat comparison.
  task automatic read_back(int s, int r, int vl, string req);
    int nb = (eff_vl(vl) + NL - 1) / NL;
    @(negedge clk); set_rd(s, r, vl);
    @(posedge clk);
    @(negedge clk); rd_start = '0;
    check64(req, "no data before first beat", 64'(rd_valid[s]), 64'd0);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      verify_beat(s, r, vl, b, req);
    end
    @(negedge clk);
    check64(req, "valid drops after last beat", 64'(rd_valid[s]), 64'd0);
    check64(req, "read stream idle", 64'(rd_busy[s]), 64'd0);
  endtask

  task automatic t_reset;
    check64("R1", "rd_busy", 64'(rd_busy), 64'd0);
    check64("R1", "rd_valid", 64'(rd_valid), 64'd0);
    check64("R1", "wr_busy", 64'(wr_busy), 64'd0);
    check64("R1", "wr_ack", 64'(wr_ack), 64'd0);
    check64("R1", "rd_data zero", 64'(|rd_data), 64'd0);
  endtask

  task automatic t_full;   // R2, R3
    write_run(0, 3, 16, 16'hA1A1, "R3");
    read_back(1, 3, 16, "R2");
    read_back(2, 3, 8, "R3");
  endtask

  task automatic t_partial;  // R4, R5
    write_run(1, 3, 6, 16'hB2B2, "R4");
    read_back(2, 3, 16, "R4");
    read_back(0, 3, 6, "R5");
  endtask

  task automatic t_clamp;  // R10
    write_run(1, 7, 20, 16'hC3C3, "R10");
    read_back(3, 7, 20, "R10");
  endtask

  task automatic t_ignore;  // R9
    write_run(0, 9, 16, 16'hD4D4, "R9");
    @(negedge clk); set_rd(1, 3, 8);
    @(posedge clk);
    @(negedge clk); set_rd(1, 9, 16);   // stream already busy
    @(negedge clk); rd_start = '0;
    verify_beat(1, 3, 8, 0, "R9");
    @(negedge clk); verify_beat(1, 3, 8, 1, "R9");
    @(negedge clk);
    check64("R9", "busy start ignored, stream idle", 64'(rd_busy[1]), 64'd0);
    check64("R9", "busy start ignored, no extra beat", 64'(rd_valid[1]), 64'd0);
    @(negedge clk); set_rd(2, 3, 0);
    @(posedge clk);
    @(negedge clk); rd_start = '0;
    check64("R9", "zero length not started", 64'(rd_busy[2]), 64'd0);
    @(negedge clk);
    check64("R9", "zero length no data", 64'(rd_valid[2]), 64'd0);
  endtask

  task automatic t_read_ports;  // R6
    for (int i = 0; i < 4; i++) write_run(0, i, 4, 16'(16'h1100 + i), "R6");
    @(negedge clk);
    for (int s = 0; s < 4; s++) set_rd(s, s, 4);
    @(posedge clk);
    @(negedge clk); rd_start = '0;
    @(negedge clk);
    check64("R6", "first grant set", 64'(rd_valid), 64'h7);
    check64("R6", "lowest priority stalled", 64'(rd_busy[3]), 64'd1);
    for (int s = 0; s < 3; s++) verify_beat(s, s, 4, 0, "R6");
    @(negedge clk);
    check64("R6", "second grant set", 64'(rd_valid), 64'h8);
    verify_beat(3, 3, 4, 0, "R6");
    @(negedge clk);
    check64("R6", "all idle", 64'(rd_valid | rd_busy), 64'd0);
  endtask

  task automatic t_write_ports;  // R7
    @(negedge clk);
    for (int s = 0; s < 4; s++) set_wr(s, 10 + s, 4);
    @(posedge clk);
    @(negedge clk); wr_start = '0;
    for (int s = 0; s < 4; s++) drive_beat(s, 10 + s, 0, 16'(16'h7700 + s));
    check64("R7", "first ack set", 64'(wr_ack), 64'h3);
    commit_beat(10, 4, 0, 16'h7700); commit_beat(11, 4, 0, 16'h7701);
    @(negedge clk);
    check64("R7", "second ack set", 64'(wr_ack), 64'hC);
    commit_beat(12, 4, 0, 16'h7702); commit_beat(13, 4, 0, 16'h7703);
    @(negedge clk);
    check64("R7", "acks done", 64'(wr_ack | wr_busy), 64'd0);
    for (int s = 0; s < 4; s++) read_back(s, 10 + s, 4, "R7");
  endtask

  task automatic t_no_bypass;  // R8
    write_run(0, 5, 4, 16'hE5E5, "R8");
    @(negedge clk); set_rd(0, 5, 4); set_wr(0, 5, 4);
    @(posedge clk);
    @(negedge clk); rd_start = '0; wr_start = '0;
    drive_beat(0, 5, 0, 16'hF6F6);
    check64("R8", "write acked with read", 64'(wr_ack[0]), 64'd1);
    @(negedge clk);
    verify_beat(0, 5, 4, 0, "R8");   // model still holds old data
    commit_beat(5, 4, 0, 16'hF6F6);
    read_back(1, 5, 4, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rd_start = '0; rd_reg = '0; rd_vl = '0;
    wr_start = '0; wr_reg = '0; wr_vl = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full;
    t_partial;
    t_clamp;
    t_ignore;
    t_read_ports;
    t_write_ports;
    t_no_bypass;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule